// File: doc/BRIEF.md
# Synchronous Burst SRAM Controller Model

This block is a clocked behavioural model of a pipelined synchronous burst SRAM with a small internal array. On every rising clock edge it decodes three chip selects, two address strobes, a burst-step input and the write enables. From these it either starts a new access at the external address, steps or holds an existing burst, deselects itself, or does nothing.

One strobe serves the processor side and always starts a read. It is disregarded while the first select is inactive. The other strobe serves the memory-controller side and starts a read or a write according to the combined write term. While both strobes are inactive, a 2-bit linear burst counter over the low address bits either advances or holds.

Writes are byte-masked and take their data in the same clock as their address. Read data is registered and is driven one clock after its address cycle. The output enable acts without a clock. The shared data bus is split into an input, an output and a drive enable, so that the tri-state buffer can sit in the pad ring. A sleep input stops all activity and releases the bus at once. When sleep is released, the block waits a fixed recovery time of two clocks before it accepts a new command.

Top module: `sbsram`

## Requirements
- R1: After reset the data bus is not driven (`dq_oe` = 0), even with `out_en_n` low.
- R2: With the chip selected (`sel_a_n`=0, `sel_b`=1, `sel_c_n`=0), `strb_ctl_n` low and `strb_proc_n` high, a new access starts at `addr_i`. A read returns the stored word on `dq_o` with `dq_oe`=1 after the next rising edge.
- R3: With the chip selected, an access started by `strb_proc_n` low is a read even when `wr_all_n` is low, and it leaves the array unchanged.
- R4: While `sel_a_n` is high, `strb_proc_n` is disregarded. Then `strb_ctl_n` low deselects the block (no access, bus released). `strb_ctl_n` high with `burst_step_n` low continues an active burst.
- R5: A strobe taken while `sel_b` is low or `sel_c_n` is high deselects the block. No array access occurs and the bus is released.
- R6: With both strobes inactive, `burst_step_n` low advances the 2 low address bits by one, modulo 4, starting from the address that opened the burst. Higher address bits stay fixed.
- R7: With both strobes inactive, `burst_step_n` high repeats the access at the current burst address.
- R8: A burst continue or hold is a write when the combined write term is active, and a read otherwise.
- R9: The combined write term is active when `wr_all_n` is low, or when `wr_bytes_n` is low and at least one `byte_en_n` bit is low. `wr_all_n` low writes every byte. Otherwise only byte i (bits 8i+7:8i) with `byte_en_n[i]` low is written.
- R10: `dq_oe` follows `out_en_n` without a clock edge. The bus is not driven in the cycle that follows a write access, whatever the state of `out_en_n`.
- R11: While `sleep_req` is high, `dq_oe` is 0 and every command is disregarded; writes do not reach the array.
- R12: After `sleep_req` falls, commands sampled on the first two rising edges are disregarded. The third edge accepts a command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all sampling on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_i | input | ADDR_W | External word address |
| sel_a_n | input | 1 | Chip select, active low; also qualifies the processor strobe |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| strb_proc_n | input | 1 | Processor-side address strobe, active low, read-only start |
| strb_ctl_n | input | 1 | Controller-side address strobe, active low |
| burst_step_n | input | 1 | Burst advance when low, hold when high |
| wr_all_n | input | 1 | Write of all bytes, active low |
| wr_bytes_n | input | 1 | Enables the per-byte write enables, active low |
| byte_en_n | input | NUM_BYTES | Per-byte write enables, active low |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| sleep_req | input | 1 | Sleep request, active high |
| dq_i | input | DATA_W | Write data from the bus pads |
| dq_o | output | DATA_W | Read data toward the bus pads |
| dq_oe | output | 1 | Pad drive enable for dq_o |

## Verification
The bench builds the block with its defaults: a 32-bit word split into four byte lanes and a 64-word array. Four lanes make mixed byte-enable patterns distinguishable, so a write touching bytes 0 and 2 can be told apart from full or empty writes. The array is deep enough that a burst started at word 18 exposes the wrap from 19 back to 16, with the upper address bits held. The two-clock recovery is short enough for the bench to check each ignored edge and the first accepted one one by one.

// File: rtl/sbsram_pkg.sv
`timescale 1ns/1ps
package sbsram_pkg;
   typedef enum logic [1:0] {
      ACC_NONE  = 2'd0,
      ACC_READ  = 2'd1,
      ACC_WRITE = 2'd2
   } acc_kind_e;
endpackage

// File: rtl/sbsram_ctrl.sv
`timescale 1ns/1ps
module sbsram_ctrl
   import sbsram_pkg::*;
#(
   parameter int ADDR_W     = 6,
   parameter int NUM_BYTES  = 4,
   parameter int BURST_BITS = 2,
   parameter int REC_CYCLES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [ADDR_W-1:0]    addr_i,
   input  logic                 sel_a_n,
   input  logic                 sel_b,
   input  logic                 sel_c_n,
   input  logic                 strb_proc_n,
   input  logic                 strb_ctl_n,
   input  logic                 burst_step_n,
   input  logic                 wr_all_n,
   input  logic                 wr_bytes_n,
   input  logic [NUM_BYTES-1:0] byte_en_n,
   input  logic                 sleep_req,
   output acc_kind_e            acc_kind,
   output logic [ADDR_W-1:0]    acc_addr,
   output logic [NUM_BYTES-1:0] wr_mask
);
   localparam int REC_W = $clog2(REC_CYCLES + 1);
   localparam logic [REC_W-1:0] REC_LOAD = REC_W'(REC_CYCLES);

   logic [REC_W-1:0]      rec_cnt;
   logic                  awake;
   logic                  chip_sel, proc_start, ctl_start, wr_req;
   logic                  busy_q, busy_d;
   logic [ADDR_W-1:0]     base_q, base_d;
   logic [BURST_BITS-1:0] cnt_q, cnt_d, step;
   logic [BURST_BITS-1:0] lo_sum;

   // sleep and recovery timing
   always_ff @(posedge clk) begin
      if (!rst_n)              rec_cnt <= '0;
      else if (sleep_req)      rec_cnt <= REC_LOAD;
      else if (rec_cnt != '0)  rec_cnt <= rec_cnt - 1'b1;
   end

   assign awake      = !sleep_req && (rec_cnt == '0);
   assign chip_sel   = !sel_a_n && sel_b && !sel_c_n;
   assign proc_start = !strb_proc_n && !sel_a_n;
   assign ctl_start  = !proc_start && !strb_ctl_n;
   assign wr_req     = !wr_all_n || (!wr_bytes_n && (|(~byte_en_n)));
   assign step       = cnt_q + BURST_BITS'(!burst_step_n);
   assign lo_sum     = base_q[BURST_BITS-1:0] + step;

   always_comb begin
      acc_kind = ACC_NONE;
      acc_addr = addr_i;
      busy_d   = busy_q;
      base_d   = base_q;
      cnt_d    = cnt_q;
      if (awake) begin
         if (proc_start || ctl_start) begin
            if (chip_sel) begin
               busy_d   = 1'b1;
               base_d   = addr_i;
               cnt_d    = '0;
               acc_kind = (proc_start || !wr_req) ? ACC_READ : ACC_WRITE;
            end else begin
               busy_d = 1'b0;
            end
         end else if (busy_q) begin
            cnt_d    = step;
            acc_addr = {base_q[ADDR_W-1:BURST_BITS], lo_sum};
            acc_kind = wr_req ? ACC_WRITE : ACC_READ;
         end
      end
   end

   always_comb begin
      if (acc_kind != ACC_WRITE) wr_mask = '0;
      else if (!wr_all_n)        wr_mask = '1;
      else                       wr_mask = ~byte_en_n;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         base_q <= '0;
         cnt_q  <= '0;
      end else begin
         busy_q <= busy_d;
         base_q <= base_d;
         cnt_q  <= cnt_d;
      end
   end

   // R3
   proc_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!strb_proc_n && !sel_a_n && acc_kind != ACC_NONE) |-> acc_kind == ACC_READ);
   // R9
   wr_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_kind == ACC_WRITE) |-> $countones(wr_mask) > 0);
   // R11
   sleep_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sleep_req |-> acc_kind == ACC_NONE);
   // R12
   recover_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sleep_req) |-> acc_kind == ACC_NONE);
endmodule

// File: rtl/sbsram_array.sv
`timescale 1ns/1ps
module sbsram_array
   import sbsram_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int NUM_BYTES = 4,
   parameter int DEPTH     = 64
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  acc_kind_e                acc_kind,
   input  logic [$clog2(DEPTH)-1:0] acc_addr,
   input  logic [NUM_BYTES-1:0]     wr_mask,
   input  logic [DATA_W-1:0]        wr_data,
   output logic [DATA_W-1:0]        rd_data,
   output logic                     rd_vld
);
   localparam int LANE_W = DATA_W / NUM_BYTES;

   for (genvar g = 0; g < NUM_BYTES; g++) begin : g_lane
      logic [LANE_W-1:0] lane_mem [DEPTH];
      logic [LANE_W-1:0] lane_q;
      always_ff @(posedge clk) begin
         if (acc_kind == ACC_WRITE && wr_mask[g])
            lane_mem[acc_addr] <= wr_data[g*LANE_W +: LANE_W];
         if (acc_kind == ACC_READ)
            lane_q <= lane_mem[acc_addr];
      end
      assign rd_data[g*LANE_W +: LANE_W] = lane_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) rd_vld <= 1'b0;
      else        rd_vld <= (acc_kind == ACC_READ);
   end

   // R2
   rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_vld |-> $past(acc_kind) == ACC_READ);
endmodule

// File: rtl/sbsram.sv
`timescale 1ns/1ps
module sbsram
   import sbsram_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int NUM_BYTES  = 4,
   parameter int DEPTH      = 64,
   parameter int REC_CYCLES = 2,
   localparam int ADDR_W    = $clog2(DEPTH)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [ADDR_W-1:0]    addr_i,
   input  logic                 sel_a_n,
   input  logic                 sel_b,
   input  logic                 sel_c_n,
   input  logic                 strb_proc_n,
   input  logic                 strb_ctl_n,
   input  logic                 burst_step_n,
   input  logic                 wr_all_n,
   input  logic                 wr_bytes_n,
   input  logic [NUM_BYTES-1:0] byte_en_n,
   input  logic                 out_en_n,
   input  logic                 sleep_req,
   input  logic [DATA_W-1:0]    dq_i,
   output logic [DATA_W-1:0]    dq_o,
   output logic                 dq_oe
);
   localparam int BURST_BITS = 2;

   if (DATA_W % NUM_BYTES != 0) begin : g_bad_lanes
      $error("sbsram: DATA_W must split evenly into NUM_BYTES lanes");
   end
   if (DEPTH < (1 << BURST_BITS) || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("sbsram: DEPTH must be a power of two of at least one burst");
   end
   if (REC_CYCLES < 1) begin : g_bad_rec
      $error("sbsram: REC_CYCLES must be at least 1");
   end

   acc_kind_e             acc_kind;
   logic [ADDR_W-1:0]     acc_addr;
   logic [NUM_BYTES-1:0]  wr_mask;
   logic                  rd_vld;

   sbsram_ctrl #(
      .ADDR_W(ADDR_W), .NUM_BYTES(NUM_BYTES),
      .BURST_BITS(BURST_BITS), .REC_CYCLES(REC_CYCLES)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n), .addr_i(addr_i),
      .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
      .strb_proc_n(strb_proc_n), .strb_ctl_n(strb_ctl_n),
      .burst_step_n(burst_step_n), .wr_all_n(wr_all_n),
      .wr_bytes_n(wr_bytes_n), .byte_en_n(byte_en_n),
      .sleep_req(sleep_req), .acc_kind(acc_kind),
      .acc_addr(acc_addr), .wr_mask(wr_mask)
   );

   sbsram_array #(
      .DATA_W(DATA_W), .NUM_BYTES(NUM_BYTES), .DEPTH(DEPTH)
   ) u_array (
      .clk(clk), .rst_n(rst_n), .acc_kind(acc_kind),
      .acc_addr(acc_addr), .wr_mask(wr_mask), .wr_data(dq_i),
      .rd_data(dq_o), .rd_vld(rd_vld)
   );

   assign dq_oe = rd_vld && !out_en_n && !sleep_req;

   // R10
   wr_bus_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(acc_kind) == ACC_WRITE) |-> !dq_oe);
endmodule

// File: tb/sbsram_tb.sv
`timescale 1ns/1ps
module sbsram_tb;
   logic        clk = 1'b0;
   logic        rst_n;
   logic [5:0]  addr_i;
   logic        sel_a_n, sel_b, sel_c_n;
   logic        strb_proc_n, strb_ctl_n, burst_step_n;
   logic        wr_all_n, wr_bytes_n;
   logic [3:0]  byte_en_n;
   logic        out_en_n, sleep_req;
   logic [31:0] dq_i, dq_o;
   logic        dq_oe;
   int          checks = 0;
   int          errors = 0;
   bit          done = 0;

   always #10 clk = ~clk;

   sbsram u_dut (
      .clk(clk), .rst_n(rst_n), .addr_i(addr_i),
      .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
      .strb_proc_n(strb_proc_n), .strb_ctl_n(strb_ctl_n),
      .burst_step_n(burst_step_n), .wr_all_n(wr_all_n),
      .wr_bytes_n(wr_bytes_n), .byte_en_n(byte_en_n),
      .out_en_n(out_en_n), .sleep_req(sleep_req),
      .dq_i(dq_i), .dq_o(dq_o), .dq_oe(dq_oe)
   );

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic defaults();
      sel_a_n = 0; sel_b = 1; sel_c_n = 0;
      strb_proc_n = 1; strb_ctl_n = 1; burst_step_n = 1;
      wr_all_n = 1; wr_bytes_n = 1; byte_en_n = 4'hF;
      out_en_n = 0; sleep_req = 0; addr_i = '0; dq_i = '0;
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic desel();
      defaults(); sel_a_n = 1; strb_ctl_n = 0; step();
   endtask

   task automatic wr_full(logic [5:0] a, logic [31:0] d);
      defaults(); strb_ctl_n = 0; wr_all_n = 0; addr_i = a; dq_i = d; step();
   endtask

   task automatic rd_ctl(logic [5:0] a);
      defaults(); strb_ctl_n = 0; addr_i = a; step();
   endtask

   task automatic expect_rd(string req, logic [31:0] exp);
      chk({req, " drive"}, 32'(dq_oe), 32'd1);
      chk({req, " data"}, dq_o, exp);
   endtask

   task automatic t_reset();
      chk("R1 bus idle after reset", 32'(dq_oe), 32'd0);
   endtask

   task automatic t_basic();
      wr_full(6'd5, 32'hA5A5_0001);
      chk("R10 no drive after write", 32'(dq_oe), 32'd0);
      desel();
      rd_ctl(6'd5);
      expect_rd("R2 read word 5", 32'hA5A5_0001);
      desel();
   endtask

   task automatic t_proc_read();
      wr_full(6'd9, 32'h0BAD_BEEF);
      desel();
      defaults(); strb_proc_n = 0; wr_all_n = 0; addr_i = 6'd9; dq_i = 32'h1234_5678; step();
      expect_rd("R3 processor strobe reads", 32'h0BAD_BEEF);
      desel();
      rd_ctl(6'd9);
      expect_rd("R3 array unchanged", 32'h0BAD_BEEF);
      desel();
   endtask

   task automatic t_bytes();
      wr_full(6'd12, 32'h1122_3344);
      desel();
      defaults(); strb_ctl_n = 0; wr_bytes_n = 0; byte_en_n = 4'b1010;
      addr_i = 6'd12; dq_i = 32'hAABB_CCDD; step();
      chk("R9 byte write no drive", 32'(dq_oe), 32'd0);
      desel();
      defaults(); strb_ctl_n = 0; byte_en_n = 4'h0; addr_i = 6'd12; step();
      expect_rd("R9 lanes 0 and 2 only, byte enables without group enable read", 32'h11BB_33DD);
      desel();
   endtask

   task automatic fill_burst();
      for (int i = 16; i < 20; i++) wr_full(6'(i), 32'hC000_0000 + 32'(i));
      desel();
   endtask

   task automatic cont(logic step_n);
      defaults(); burst_step_n = step_n; step();
   endtask

   task automatic t_burst();
      rd_ctl(6'd18);
      expect_rd("R6 start 18", 32'hC000_0012);
      cont(0); expect_rd("R6 beat 19", 32'hC000_0013);
      cont(0); expect_rd("R6 wrap 16", 32'hC000_0010);
      cont(0); expect_rd("R6 beat 17", 32'hC000_0011);
      cont(0); expect_rd("R6 back to 18", 32'hC000_0012);
      desel();
   endtask

   task automatic t_suspend();
      rd_ctl(6'd16);
      cont(1); expect_rd("R7 hold 16", 32'hC000_0010);
      cont(1); expect_rd("R7 hold 16 again", 32'hC000_0010);
      cont(0); expect_rd("R7 then step 17", 32'hC000_0011);
      desel();
   endtask

   task automatic t_burst_write();
      wr_full(6'd20, 32'hD000_0020);
      desel();
      defaults(); strb_proc_n = 0; addr_i = 6'd20; step();
      expect_rd("R8 burst opens as read", 32'hD000_0020);
      defaults(); burst_step_n = 0; wr_all_n = 0; dq_i = 32'hE000_0021; step();
      chk("R8 burst write no drive", 32'(dq_oe), 32'd0);
      defaults(); burst_step_n = 0; wr_all_n = 0; dq_i = 32'hE000_0022; step();
      desel();
      rd_ctl(6'd21); expect_rd("R8 word 21 written", 32'hE000_0021);
      desel();
      rd_ctl(6'd22); expect_rd("R8 word 22 written", 32'hE000_0022);
      desel();
   endtask

   task automatic t_sel_a_high();
      rd_ctl(6'd16);
      defaults(); sel_a_n = 1; strb_proc_n = 0; burst_step_n = 0; step();
      expect_rd("R4 continue with processor strobe ignored", 32'hC000_0011);
      defaults(); sel_a_n = 1; strb_proc_n = 0; strb_ctl_n = 0; step();
      chk("R4 controller strobe deselects", 32'(dq_oe), 32'd0);
      defaults(); sel_a_n = 1; burst_step_n = 0; step();
      chk("R4 no burst after deselect", 32'(dq_oe), 32'd0);
   endtask

   task automatic t_desel();
      defaults(); sel_b = 0; strb_ctl_n = 0; wr_all_n = 0; addr_i = 6'd5; dq_i = 32'hDEAD_0000; step();
      chk("R5 sel_b low no drive", 32'(dq_oe), 32'd0);
      defaults(); sel_c_n = 1; strb_proc_n = 0; addr_i = 6'd5; step();
      chk("R5 sel_c_n high no read", 32'(dq_oe), 32'd0);
      rd_ctl(6'd5);
      expect_rd("R5 word 5 untouched", 32'hA5A5_0001);
      desel();
   endtask

   task automatic t_oe();
      rd_ctl(6'd5);
      chk("R10 driven with enable low", 32'(dq_oe), 32'd1);
      out_en_n = 1; #1;
      chk("R10 released at once", 32'(dq_oe), 32'd0);
      out_en_n = 0; #1;
      chk("R10 driven again at once", 32'(dq_oe), 32'd1);
      desel();
   endtask

   task automatic t_sleep();
      rd_ctl(6'd5);
      sleep_req = 1; #1;
      chk("R11 sleep releases bus", 32'(dq_oe), 32'd0);
      defaults(); sleep_req = 1; strb_ctl_n = 0; wr_all_n = 0; addr_i = 6'd5; dq_i = 32'h5EE9_0000;
      step(); step();
      chk("R11 no drive while asleep", 32'(dq_oe), 32'd0);
      rd_ctl(6'd5);
      chk("R12 first recovery edge ignored", 32'(dq_oe), 32'd0);
      rd_ctl(6'd5);
      chk("R12 second recovery edge ignored", 32'(dq_oe), 32'd0);
      rd_ctl(6'd5);
      expect_rd("R12 third edge accepted, R11 sleep write dropped", 32'hA5A5_0001);
      desel();
   endtask

   initial begin
      rst_n = 0;
      defaults();
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1;
      step();
      t_reset();
      t_basic();
      t_proc_read();
      t_bytes();
      fill_burst();
      t_burst();
      t_suspend();
      t_burst_write();
      t_sel_a_high();
      t_desel();
      t_oe();
      t_sleep();
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule